// File: doc/BRIEF.md
# Configurable Phase-Frequency Detector

This block compares two rising-edge streams inside one fast clock domain. One stream is a reference clock and the other is a divided oscillator clock. It reports the phase or frequency error in two ways. The first is a pair of active-low error pulses, one per side. The second is a single-ended charge-pump command made of a source request, a sink request and an output enable. The output enable is low whenever the pump should float.

A set of configuration inputs selects:
- the error polarity,
- an output disable,
- a standby state,
- gating of the lock indicator,
- a three-bit charge-pump current code.

The current code is passed on together with its decoded percentage, for use by the analog pump that sits outside this block. Every detection cycle ends with a coincident low pulse of a guaranteed number of clock cycles on both error outputs, so the detector has no dead zone around zero phase error.

Both edge inputs pass through a synchronizer. The block clock must run at least four times faster than either input.

Top module: `pfd_top`

## Requirements
- R1: While reset is low, and right after it is released:
  - both error outputs are high;
  - `cp_up`, `cp_dn` and `cp_oe` are low;
  - `lock_out` is low;
  - `cur_code` is 0 and `cur_pct` is 70.
- R2: With `cfg_pol`=0, a feedback rising edge that arrives before the reference edge drives `err_fb_n` low and `cp_dn`=1 with `cp_oe`=1, while `err_ref_n` stays high. The response appears on the third clock edge after the input is sampled high.
- R3: With `cfg_pol`=0, a reference edge that leads the feedback edge drives `err_ref_n` low and `cp_up`=1 with `cp_oe`=1, while `err_fb_n` stays high.
- R4: With `cfg_pol`=1, the roles swap:
  - a leading feedback edge drives `err_ref_n` low with `cp_up`=1;
  - a leading reference edge drives `err_fb_n` low with `cp_dn`=1.
- R5: Once both edges have been seen, both error outputs are low together for exactly `MIN_W` cycles (default 2), with `cp_oe`=0. After that, both return high.
- R6: A change to `cfg_dis` or `cfg_stby` takes effect at the next clock edge. While either is 1, both error outputs are high and `cp_up`, `cp_dn` and `cp_oe` are 0.
- R7: Entering disable or standby clears any pending detector state, so no stale error pulse appears when the outputs are enabled again.
- R8: `lock_out` is the AND of `err_ref_n` and `err_fb_n` while `cfg_lock_en`=1. It is 0 whenever `cfg_lock_en`=0.
- R9: `cur_code` = {`cfg_range`,`cfg_mag`}, one cycle after the inputs are applied. `cur_pct` decodes it as follows:
  - with `cfg_range`=0, `cfg_mag` 0/1/2/3 gives 70/80/90/100;
  - with `cfg_range`=1, `cfg_mag` 0/1/2/3 gives 25/50/75/100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_in | input | 1 | Reference edge stream |
| fb_in | input | 1 | Divided oscillator edge stream |
| cfg_pol | input | 1 | Error polarity select |
| cfg_dis | input | 1 | Force outputs to rest |
| cfg_stby | input | 1 | Standby, forces outputs to rest |
| cfg_lock_en | input | 1 | Enable the lock indicator |
| cfg_range | input | 1 | Current range select |
| cfg_mag | input | 2 | Current magnitude step |
| err_ref_n | output | 1 | Reference-side active-low error pulse |
| err_fb_n | output | 1 | Feedback-side active-low error pulse |
| cp_up | output | 1 | Charge-pump source request |
| cp_dn | output | 1 | Charge-pump sink request |
| cp_oe | output | 1 | Charge-pump drive enable, low means float |
| lock_out | output | 1 | Gated lock indicator |
| cur_code | output | 3 | Registered current code for the pump |
| cur_pct | output | 7 | Decoded pump current in percent |

## Verification
The bench applies the following edge patterns under both polarity settings:
- a feedback edge leading the reference by four cycles;
- a reference edge leading the feedback edge;
- two exactly coincident edges.

The leading cases tell the two error sides apart and the two pump directions apart. The coincident case isolates the minimum-width joint pulse and shows that the pump floats when the edges match.

A detection cycle is interrupted by disable and, separately, by standby, to show the forced rest state and that no stale pulse survives re-enabling. The lock indicator is observed with gating both on and off. All eight current codes are stepped through.

// File: rtl/pfd_pkg.sv
// Shared configuration type and current-code decode for the detector.
package pfd_pkg;

    typedef struct packed {
        logic       pol;
        logic       dis;
        logic       stby;
        logic       lock_en;
        logic       range;
        logic [1:0] mag;
    } pfd_cfg_t;

    // Percentage of full pump current for a range bit and magnitude step.
    function automatic logic [6:0] pfd_pct(input logic range, input logic [1:0] mag);
        logic [6:0] step;
        step = {5'd0, mag};
        if (range) pfd_pct = 7'd25 * (step + 7'd1);
        else       pfd_pct = 7'd70 + 7'd10 * step;
    endfunction

endpackage

// File: rtl/pfd_edge_sync.sv
// Brings one asynchronous edge stream into the block clock domain through a
// STAGES-deep flop chain, then flags each rising edge as a one-cycle pulse.
// Assumes the input stays high and low for at least two block clocks each.
module pfd_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              last;

    // Shift the input through the synchronizer and keep the previous level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
            last  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], din};
            last  <= chain[STAGES-1];
        end
    end

    // One-cycle pulse on a synchronized low-to-high transition.
    always_comb rise = chain[STAGES-1] & ~last;

    // R2
    rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

endmodule

// File: rtl/pfd_core.sv
// Two edge-set state flops, one per input. Once both are set, they are
// cleared together after MIN_W cycles, which sets the coincident pulse width.
// A gate input clears both at once and holds them clear.
module pfd_core #(
    parameter int MIN_W = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rise_ref,
    input  logic rise_fb,
    input  logic gate,
    output logic st_ref,
    output logic st_fb
);
    localparam int CNT_W = (MIN_W < 2) ? 1 : $clog2(MIN_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(MIN_W - 1);

    logic [CNT_W-1:0] cnt;
    logic             both;
    logic             clr;

    // Both sides set; clear when the joint window has run its length.
    always_comb begin
        both = st_ref & st_fb;
        clr  = both & (cnt == LAST);
    end

    // Set on an edge, clear after the joint window, hold clear while gated.
    always_ff @(posedge clk) begin
        if (!rst_n || gate) begin
            st_ref <= 1'b0;
            st_fb  <= 1'b0;
            cnt    <= '0;
        end else begin
            st_ref <= (st_ref & ~clr) | rise_ref;
            st_fb  <= (st_fb  & ~clr) | rise_fb;
            cnt    <= (both && !clr) ? cnt + 1'b1 : '0;
        end
    end

    // R5
    joint_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !gate && !rise_ref && !rise_fb) |=> (!st_ref && !st_fb));

    // R7
    gate_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gate |=> (!st_ref && !st_fb));

endmodule

// File: rtl/pfd_outmux.sv
// Registers the configuration, then drives the outputs from the detector
// state:
//   - applies polarity, and forces the rest state under disable or standby;
//   - drives the three-state pump command and the gated lock indicator;
//   - decodes the pump current code.
module pfd_outmux
    import pfd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  pfd_cfg_t   cfg_in,
    input  logic       st_ref,
    input  logic       st_fb,
    output logic       gate,
    output logic       err_ref_n,
    output logic       err_fb_n,
    output logic       cp_up,
    output logic       cp_dn,
    output logic       cp_oe,
    output logic       lock_out,
    output logic [2:0] cur_code,
    output logic [6:0] cur_pct
);
    pfd_cfg_t cfg_q;
    logic     up_raw;
    logic     dn_raw;

    // Configuration takes effect on the clock edge after it is applied.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_in;
    end

    // Map detector state to error pulses and pump requests.
    always_comb begin
        gate      = cfg_q.dis | cfg_q.stby;
        up_raw    = cfg_q.pol ? st_fb  : st_ref;
        dn_raw    = cfg_q.pol ? st_ref : st_fb;
        err_ref_n = gate | ~(cfg_q.pol ? st_fb  : st_ref);
        err_fb_n  = gate | ~(cfg_q.pol ? st_ref : st_fb);
        cp_oe     = ~gate & (up_raw ^ dn_raw);
        cp_up     = cp_oe & up_raw;
        cp_dn     = cp_oe & dn_raw;
        lock_out  = cfg_q.lock_en & err_ref_n & err_fb_n;
        cur_code  = {cfg_q.range, cfg_q.mag};
        cur_pct   = pfd_pct(cfg_q.range, cfg_q.mag);
    end

    // R2
    pump_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cp_up, cp_dn}));

    // R6
    gate_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate) |=> (!st_ref && !st_fb));

endmodule

// File: rtl/pfd_top.sv
// Phase-frequency detector top level: two edge synchronizers, the state core
// and the output stage. Assumes clk is at least 4x faster than either input.
module pfd_top #(
    parameter int MIN_W       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_in,
    input  logic       fb_in,
    input  logic       cfg_pol,
    input  logic       cfg_dis,
    input  logic       cfg_stby,
    input  logic       cfg_lock_en,
    input  logic       cfg_range,
    input  logic [1:0] cfg_mag,
    output logic       err_ref_n,
    output logic       err_fb_n,
    output logic       cp_up,
    output logic       cp_dn,
    output logic       cp_oe,
    output logic       lock_out,
    output logic [2:0] cur_code,
    output logic [6:0] cur_pct
);
    import pfd_pkg::*;

    logic     rise_ref, rise_fb, st_ref, st_fb, gate;
    pfd_cfg_t cfg;

    // Pack the configuration inputs.
    always_comb cfg = '{pol: cfg_pol, dis: cfg_dis, stby: cfg_stby,
                        lock_en: cfg_lock_en, range: cfg_range, mag: cfg_mag};

    pfd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_ref (
        .clk(clk), .rst_n(rst_n), .din(ref_in), .rise(rise_ref));

    pfd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_fb (
        .clk(clk), .rst_n(rst_n), .din(fb_in), .rise(rise_fb));

    pfd_core #(.MIN_W(MIN_W)) u_core (
        .clk(clk), .rst_n(rst_n), .rise_ref(rise_ref), .rise_fb(rise_fb),
        .gate(gate), .st_ref(st_ref), .st_fb(st_fb));

    pfd_outmux u_out (
        .clk(clk), .rst_n(rst_n), .cfg_in(cfg), .st_ref(st_ref), .st_fb(st_fb),
        .gate(gate), .err_ref_n(err_ref_n), .err_fb_n(err_fb_n),
        .cp_up(cp_up), .cp_dn(cp_dn), .cp_oe(cp_oe), .lock_out(lock_out),
        .cur_code(cur_code), .cur_pct(cur_pct));

endmodule

// File: tb/pfd_top_bench.sv
// Scoreboard bench: driver tasks queue expected output snapshots tagged with
// a cycle number; the monitor compares them on the falling edge of that cycle.
module pfd_top_bench;

    typedef struct {
        int         at;
        string      req;
        logic [5:0] vec;   // {err_ref_n, err_fb_n, cp_up, cp_dn, cp_oe, lock_out}
        logic [2:0] code;
        logic [6:0] pct;
    } item_t;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ref_in = 0, fb_in = 0, cfg_pol = 0, cfg_dis = 0, cfg_stby = 0;
    logic cfg_lock_en = 0, cfg_range = 0;
    logic [1:0] cfg_mag = 0;
    logic err_ref_n, err_fb_n, cp_up, cp_dn, cp_oe, lock_out;
    logic [2:0] cur_code;
    logic [6:0] cur_pct;

    int total = 0, bad = 0, cyc = 0;
    bit finished = 0;
    item_t q[$];
    logic [2:0] code_now = 3'd0;
    logic [6:0] pct_now  = 7'd70;
    int pct_tbl [2][4] = '{'{70, 80, 90, 100}, '{25, 50, 75, 100}};

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pfd_top u_pfd_top (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .fb_in(fb_in),
        .cfg_pol(cfg_pol), .cfg_dis(cfg_dis), .cfg_stby(cfg_stby),
        .cfg_lock_en(cfg_lock_en), .cfg_range(cfg_range), .cfg_mag(cfg_mag),
        .err_ref_n(err_ref_n), .err_fb_n(err_fb_n), .cp_up(cp_up), .cp_dn(cp_dn),
        .cp_oe(cp_oe), .lock_out(lock_out), .cur_code(cur_code), .cur_pct(cur_pct));

    task automatic compare(input item_t it);
        logic [5:0] act;
        act = {err_ref_n, err_fb_n, cp_up, cp_dn, cp_oe, lock_out};
        total++;
        if (act !== it.vec || cur_code !== it.code || cur_pct !== it.pct) begin
            bad++;
            $display("FAIL %s cyc=%0d actual=%b/%0d/%0d expected=%b/%0d/%0d",
                     it.req, cyc, act, cur_code, cur_pct, it.vec, it.code, it.pct);
        end
    endtask

    task automatic push(input int at, input string req, input logic [5:0] vec);
        item_t it;
        it = '{at: at, req: req, vec: vec, code: code_now, pct: pct_now};
        q.push_back(it);
    endtask

    // Monitor: compare every queued item in its cycle.
    initial begin
        forever begin
            @(negedge clk);
            while (q.size() > 0 && q[0].at <= cyc) begin
                item_t it;
                it = q.pop_front();
                compare(it);
            end
        end
    end

    task automatic settle();
        while (q.size() > 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // Drive ref and fb each high for two cycles from given offsets.
    task automatic run_pair(input int dref, input int dfb, input int len);
        for (int k = 0; k < len; k++) begin
            ref_in = (k >= dref && k < dref + 2);
            fb_in  = (k >= dfb  && k < dfb  + 2);
            @(negedge clk);
        end
        ref_in = 0; fb_in = 0;
    endtask

    // One leading-edge scenario; lead_fb selects which side comes first.
    task automatic lead_case(input bit pol, input bit lead_fb, input string req);
        int c0;
        logic l;
        logic [1:0] lead_err;
        logic [1:0] lead_cp;
        l = cfg_lock_en;
        // Error side and pump direction for the early input.
        lead_err = (lead_fb ^ pol) ? 2'b10 : 2'b01;
        lead_cp  = (lead_fb ^ pol) ? 2'b01 : 2'b10;
        c0 = cyc;
        push(c0 + 3, req, {lead_err, lead_cp, 1'b1, 1'b0});
        push(c0 + 6, req, {lead_err, lead_cp, 1'b1, 1'b0});
        push(c0 + 7, "R5", 6'b000000);
        push(c0 + 8, "R5", 6'b000000);
        push(c0 + 9, "R5", {5'b11000, l});
        if (lead_fb) run_pair(4, 0, 16);
        else         run_pair(0, 4, 16);
        settle();
    endtask

    // Interrupt a pending pulse with disable or standby, then re-enable.
    task automatic gate_case(input bit use_stby, input string req);
        int c0;
        logic l;
        l = cfg_lock_en;
        c0 = cyc;
        push(c0 + 3, "R2", {4'b1001, 1'b1, 1'b0});
        push(c0 + 5, req,  {5'b11000, l});
        push(c0 + 7, "R7", {5'b11000, l});
        push(c0 + 10, "R7", {5'b11000, l});
        for (int k = 0; k < 14; k++) begin
            fb_in = (k < 2);
            if (use_stby) cfg_stby = (k >= 4 && k < 6);
            else          cfg_dis  = (k >= 4 && k < 6);
            @(negedge clk);
        end
        settle();
    endtask

    // Driver: scenarios in sequence.
    initial begin
        int c0;
        item_t it;
        @(negedge clk);
        it = '{at: 0, req: "R1", vec: 6'b110000, code: 3'd0, pct: 7'd70};
        compare(it);
        repeat (3) @(negedge clk);
        rst_n = 1;
        push(cyc + 1, "R1", 6'b110000);
        settle();

        // Lock gating off then on, polarity low.
        lead_case(0, 1, "R2");
        cfg_lock_en = 1;
        @(negedge clk);
        push(cyc + 1, "R8", 6'b110001);
        settle();
        lead_case(0, 1, "R2");
        lead_case(0, 0, "R3");

        // Coincident edges: joint pulse only.
        c0 = cyc;
        push(c0 + 3, "R5", 6'b000000);
        push(c0 + 4, "R5", 6'b000000);
        push(c0 + 5, "R8", 6'b110001);
        run_pair(0, 0, 12);
        settle();

        // Polarity high swaps roles.
        cfg_pol = 1;
        @(negedge clk);
        settle();
        lead_case(1, 1, "R4");
        lead_case(1, 0, "R4");
        cfg_pol = 0;
        @(negedge clk);
        settle();

        gate_case(0, "R6");
        gate_case(1, "R6");

        // Lock gating off: lock stays low through a matched cycle.
        cfg_lock_en = 0;
        @(negedge clk);
        c0 = cyc;
        push(c0 + 6, "R8", 6'b110000);
        run_pair(0, 0, 10);
        settle();

        // Current codes.
        for (int r = 0; r < 2; r++) begin
            for (int m = 0; m < 4; m++) begin
                cfg_range = r[0];
                cfg_mag   = m[1:0];
                code_now  = {r[0], m[1:0]};
                pct_now   = 7'(pct_tbl[r][m]);
                push(cyc + 1, "R9", 6'b110000);
                @(negedge clk);
                settle();
            end
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL R1 watchdog actual=timeout expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule